// File: doc/BRIEF.md
# Queue Entry Timeout Tracker

This block watches the slots of a transaction tracking queue and reports any slot that stays occupied longer than a programmable limit. Every slot has a small state machine that is started by an allocate strobe and stopped by a deallocate strobe. All slots share one master timer, which is a divide-by-8 prescaler driving a 24-bit wrap-around counter. A configuration field picks how many low bits of that counter form the timeout window. Each time the selected bits wrap, a tick pulse goes to every slot.

Each slot counts ticks in a 2-bit age. A slot that sees its second tick while still occupied has timed out. This gives a timeout of one to two tick periods, depending on where the allocation falls within a tick period. A timeout sets a sticky fatal-error flag and raises the interrupt. The number of the first failing slot is latched. The failing slot itself stays occupied, because only a deallocate strobe or a new allocation moves it out of the expired state. The queue payload is outside this block.

Slot states:
- `ENT_FREE`: the slot is empty.
- `ENT_TRACK`: the slot is occupied and its age is counting.
- `ENT_EXPIRED`: the slot is occupied and has already reported its timeout.

Slot transitions:
- FREE→TRACK on allocate.
- TRACK→TRACK on a re-allocate, which clears the age, or on a tick, which increments the age.
- TRACK→EXPIRED on the tick that brings the age to 2.
- TRACK→FREE and EXPIRED→FREE on deallocate.
- EXPIRED→TRACK on allocate.

Top module: `qtimeout_tracker`

## Requirements
- R1: Reset, whether at start-up or in the middle of operation, leaves every slot free. After reset `entry_valid_o` is 0, `fatal_o` and `irq_o` are low, and `first_idx_o` is 0.
- R2: An allocate strobe on slot i sets `entry_valid_o[i]` on the next cycle. A deallocate strobe alone clears it on the next cycle. A deallocate strobe on a free slot has no effect.
- R3: The master timer advances once every 8 clocks. It emits a tick every 8·2^W clocks, where W is the selected width. The first tick comes 8·2^W clocks after the edge that wrote the width.
- R4: A write with `cfg_addr_i`=0 loads W from `cfg_wdata_i[4:0]` and restarts the timer from zero. A value below 8 is treated as 8, and a value above 24 is treated as 24. After reset W is 24.
- R5: An occupied slot times out on the second tick after the edge that allocated it. A tick on the allocation edge itself does not count. `fatal_o` and `irq_o` rise on the edge of that second tick, and not one cycle earlier.
- R6: A slot that has timed out stays valid.
- R7: `fatal_o` is sticky. A write with `cfg_addr_i`=1 and `cfg_wdata_i[0]`=1 clears it. If a timeout occurs on the same edge as the clear, the timeout wins. `irq_o` always equals `fatal_o`.
- R8: `first_idx_o` captures the lowest-numbered slot among those that time out on the edge where `fatal_o` becomes set. It holds that value while `fatal_o` stays set.
- R9: An expired slot raises no further error until it is allocated again, after which it can time out again. A slot that is deallocated before its second tick raises no error.
- R10: When allocate and deallocate hit the same slot on the same edge, the allocate wins. The slot becomes or stays valid, and its age restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_i | input | 16 | Per-slot allocate strobes |
| dealloc_i | input | 16 | Per-slot deallocate strobes |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 1 | 0 = timeout width register, 1 = error status register |
| cfg_wdata_i | input | 5 | Write data: width in [4:0], or write-1-to-clear in [0] |
| entry_valid_o | output | 16 | Per-slot occupied flag |
| fatal_o | output | 1 | Sticky fatal timeout flag |
| first_idx_o | output | 4 | Number of the first slot that timed out |
| irq_o | output | 1 | Interrupt, a level copy of the fatal flag |

## Verification
The bound checker verifies the following properties on every cycle:
- The fatal flag holds while no clear is written.
- The latched slot number stays stable while the flag is set.
- Every expiry pulse is followed by a set flag, and the expired slot is still valid afterwards.
- An allocate that coincides with a deallocate leaves the slot valid.
- A lone deallocate frees the slot.
- Ticks never come back to back.

Exact timing needs the bench's scripted scenarios, because the tick spacing depends on the programmed width. These scenarios check the edge on which a timeout fires, the one-to-two-period window, clamping of out-of-range widths, lowest-slot selection, the absence of a repeated error from an expired slot, and a clear that collides with a new expiry.

// File: rtl/qtt_pkg.sv
package qtt_pkg;

    typedef enum logic [1:0] {
        ENT_FREE    = 2'd0,
        ENT_TRACK   = 2'd1,
        ENT_EXPIRED = 2'd2
    } ent_state_t;

    localparam logic CFG_SEL_WIDTH  = 1'b0;
    localparam logic CFG_SEL_STATUS = 1'b1;

endpackage

// File: rtl/qtt_timer.sv
module qtt_timer #(
    parameter int TIMER_W  = 24,
    parameter int PRESCALE = 8,
    parameter int WSEL_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic [WSEL_W-1:0] width_i,
    output logic              tick_o
);
    localparam int PRE_W = $clog2(PRESCALE);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    logic [PRE_W-1:0]   presc_q;
    logic [TIMER_W-1:0] cnt_q;
    logic [TIMER_W-1:0] mask;
    logic               adv;

    assign adv = (presc_q == PRE_LAST);

    always_comb begin
        for (int i = 0; i < TIMER_W; i++) begin
            mask[i] = (WSEL_W'(i) < width_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            presc_q <= '0;
            cnt_q   <= '0;
        end else if (adv) begin
            presc_q <= '0;
            cnt_q   <= cnt_q + TIMER_W'(1);
        end else begin
            presc_q <= presc_q + PRE_W'(1);
        end
    end

    assign tick_o = adv && !restart_i && ((cnt_q & mask) == mask);

endmodule

// File: rtl/qtt_entry.sv
module qtt_entry
    import qtt_pkg::*;
#(
    parameter int AGE_W      = 2,
    parameter int EXPIRE_AGE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alloc_i,
    input  logic dealloc_i,
    input  logic tick_i,
    output logic valid_o,
    output logic expire_o
);
    localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(EXPIRE_AGE - 1);

    ent_state_t       state_q, state_d;
    logic [AGE_W-1:0] age_q, age_d;

    always_comb begin
        state_d = state_q;
        age_d   = age_q;
        unique case (state_q)
            ENT_FREE: begin
                if (alloc_i) begin
                    state_d = ENT_TRACK;
                    age_d   = '0;
                end
            end
            ENT_TRACK: begin
                if (alloc_i) begin
                    age_d = '0;
                end else if (dealloc_i) begin
                    state_d = ENT_FREE;
                    age_d   = '0;
                end else if (tick_i) begin
                    age_d = age_q + AGE_W'(1);
                    if (age_q == AGE_LAST) begin
                        state_d = ENT_EXPIRED;
                    end
                end
            end
            ENT_EXPIRED: begin
                if (alloc_i) begin
                    state_d = ENT_TRACK;
                    age_d   = '0;
                end else if (dealloc_i) begin
                    state_d = ENT_FREE;
                    age_d   = '0;
                end
            end
            default: begin
                state_d = ENT_FREE;
                age_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENT_FREE;
            age_q   <= '0;
        end else begin
            state_q <= state_d;
            age_q   <= age_d;
        end
    end

    always_comb begin
        valid_o  = (state_q != ENT_FREE);
        expire_o = (state_q == ENT_TRACK) && tick_i && !alloc_i
                   && !dealloc_i && (age_q == AGE_LAST);
    end

endmodule

// File: rtl/qtt_errlog.sv
module qtt_errlog #(
    parameter int N_ENTRIES = 16,
    parameter int IDX_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_ENTRIES-1:0] expire_i,
    input  logic                 clear_i,
    output logic                 fatal_o,
    output logic [IDX_W-1:0]     idx_o
);
    logic             fatal_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] low_idx;
    logic             any_exp;

    always_comb begin
        low_idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (expire_i[i]) begin
                low_idx = IDX_W'(i);
            end
        end
    end

    assign any_exp = |expire_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fatal_q <= 1'b0;
            idx_q   <= '0;
        end else begin
            fatal_q <= any_exp || (fatal_q && !clear_i);
            if (any_exp && (!fatal_q || clear_i)) begin
                idx_q <= low_idx;
            end
        end
    end

    assign fatal_o = fatal_q;
    assign idx_o   = idx_q;

endmodule

// File: rtl/qtimeout_tracker.sv
module qtimeout_tracker
    import qtt_pkg::*;
#(
    parameter int N_ENTRIES  = 16,
    parameter int TIMER_W    = 24,
    parameter int PRESCALE   = 8,
    parameter int MIN_W      = 8,
    parameter int AGE_W      = 2,
    parameter int EXPIRE_AGE = 2,
    parameter int IDX_W      = $clog2(N_ENTRIES),
    parameter int WSEL_W     = $clog2(TIMER_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_ENTRIES-1:0] alloc_i,
    input  logic [N_ENTRIES-1:0] dealloc_i,
    input  logic                 cfg_we_i,
    input  logic                 cfg_addr_i,
    input  logic [WSEL_W-1:0]    cfg_wdata_i,
    output logic [N_ENTRIES-1:0] entry_valid_o,
    output logic                 fatal_o,
    output logic [IDX_W-1:0]     first_idx_o,
    output logic                 irq_o
);
    logic [WSEL_W-1:0]    width_q;
    logic [WSEL_W-1:0]    width_clamped;
    logic                 width_wr;
    logic                 clr_stat;
    logic                 tick;
    logic [N_ENTRIES-1:0] expire_vec;

    assign width_wr = cfg_we_i && (cfg_addr_i == CFG_SEL_WIDTH);
    assign clr_stat = cfg_we_i && (cfg_addr_i == CFG_SEL_STATUS) && cfg_wdata_i[0];

    always_comb begin
        if (cfg_wdata_i < WSEL_W'(MIN_W)) begin
            width_clamped = WSEL_W'(MIN_W);
        end else if (cfg_wdata_i > WSEL_W'(TIMER_W)) begin
            width_clamped = WSEL_W'(TIMER_W);
        end else begin
            width_clamped = cfg_wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q <= WSEL_W'(TIMER_W);
        end else if (width_wr) begin
            width_q <= width_clamped;
        end
    end

    qtt_timer #(
        .TIMER_W (TIMER_W),
        .PRESCALE(PRESCALE),
        .WSEL_W  (WSEL_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(width_wr),
        .width_i  (width_q),
        .tick_o   (tick)
    );

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
        qtt_entry #(
            .AGE_W     (AGE_W),
            .EXPIRE_AGE(EXPIRE_AGE)
        ) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc_i  (alloc_i[g]),
            .dealloc_i(dealloc_i[g]),
            .tick_i   (tick),
            .valid_o  (entry_valid_o[g]),
            .expire_o (expire_vec[g])
        );
    end

    qtt_errlog #(
        .N_ENTRIES(N_ENTRIES),
        .IDX_W    (IDX_W)
    ) u_errlog (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire_i(expire_vec),
        .clear_i (clr_stat),
        .fatal_o (fatal_o),
        .idx_o   (first_idx_o)
    );

    assign irq_o = fatal_o;

endmodule

// File: rtl/qtt_checker.sv
module qtt_checker #(
    parameter int N_ENTRIES = 16,
    parameter int IDX_W     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_ENTRIES-1:0] alloc,
    input logic [N_ENTRIES-1:0] dealloc,
    input logic                 clr,
    input logic                 tick,
    input logic [N_ENTRIES-1:0] expire,
    input logic [N_ENTRIES-1:0] valid,
    input logic                 fatal,
    input logic [IDX_W-1:0]     first_idx
);

    a_r7_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fatal && !clr) |=> fatal);

    a_r8_index_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fatal && !clr) |=> $stable(first_idx));

    a_r5_expiry_logged: assert property (@(posedge clk) disable iff (!rst_n)
        (|expire) |=> fatal);

    a_r6_expired_stays_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (|expire) |=> ((valid & $past(expire)) == $past(expire)));

    a_r10_alloc_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(alloc & dealloc)) |=> ((valid & $past(alloc & dealloc)) == $past(alloc & dealloc)));

    a_r2_dealloc_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (|(dealloc & ~alloc)) |=> ((valid & $past(dealloc & ~alloc)) == '0));

    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    a_r9_expire_only_occupied: assert property (@(posedge clk) disable iff (!rst_n)
        ((expire & ~valid) == '0));

endmodule

bind qtimeout_tracker qtt_checker #(
    .N_ENTRIES(N_ENTRIES),
    .IDX_W    (IDX_W)
) u_qtt_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc    (alloc_i),
    .dealloc  (dealloc_i),
    .clr      (clr_stat),
    .tick     (tick),
    .expire   (expire_vec),
    .valid    (entry_valid_o),
    .fatal    (fatal_o),
    .first_idx(first_idx_o)
);

// File: tb/tb_qtimeout_tracker.sv
module tb_qtimeout_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] alloc_i = '0;
    logic [15:0] dealloc_i = '0;
    logic        cfg_we_i = 1'b0;
    logic        cfg_addr_i = 1'b0;
    logic [4:0]  cfg_wdata_i = '0;
    logic [15:0] entry_valid_o;
    logic        fatal_o;
    logic [3:0]  first_idx_o;
    logic        irq_o;

    int edges = 0;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;
    always @(posedge clk) edges <= edges + 1;

    qtimeout_tracker dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_i      (alloc_i),
        .dealloc_i    (dealloc_i),
        .cfg_we_i     (cfg_we_i),
        .cfg_addr_i   (cfg_addr_i),
        .cfg_wdata_i  (cfg_wdata_i),
        .entry_valid_o(entry_valid_o),
        .fatal_o      (fatal_o),
        .first_idx_o  (first_idx_o),
        .irq_o        (irq_o)
    );

    localparam logic [1:0] OP_DRV = 2'd0;
    localparam logic [1:0] OP_CFG = 2'd1;
    localparam logic [1:0] OP_CHK = 2'd2;

    // DRV: a=alloc, d=dealloc, aux[0]=status clear
    // CFG: aux=width value
    // CHK: a=expected valid, d=valid care mask, aux=expected index, ef=expected fatal
    typedef struct packed {
        logic [31:0] t;
        logic [1:0]  op;
        logic [15:0] a;
        logic [15:0] d;
        logic [4:0]  aux;
        logic        ef;
        logic [3:0]  req;
    } row_t;

    localparam int NR = 38;
    // width 8 written at edge 20: ticks at 20 + 2048*j
    localparam row_t ROWS [NR] = '{
        '{32'd10,    OP_CHK, 16'h0000, 16'hFFFF, 5'd0,  1'b0, 4'd1},  // R1 reset state
        '{32'd20,    OP_CFG, 16'h0000, 16'h0000, 5'd8,  1'b0, 4'd4},  // R4 width 8
        '{32'd120,   OP_DRV, 16'h0428, 16'h0000, 5'd0,  1'b0, 4'd2},  // R2 alloc 3,5,10
        '{32'd121,   OP_CHK, 16'h0428, 16'hFFFF, 5'd0,  1'b0, 4'd2},  // R2
        '{32'd3000,  OP_DRV, 16'h0000, 16'h0020, 5'd0,  1'b0, 4'd2},  // R2 free 5
        '{32'd3001,  OP_CHK, 16'h0408, 16'hFFFF, 5'd0,  1'b0, 4'd2},  // R2
        '{32'd4115,  OP_CHK, 16'h0000, 16'h0000, 5'd0,  1'b0, 4'd5},  // R5 not early
        '{32'd4116,  OP_CHK, 16'h0000, 16'h0000, 5'd3,  1'b1, 4'd5},  // R5 fires
        '{32'd4116,  OP_CHK, 16'h0408, 16'hFFFF, 5'd3,  1'b1, 4'd6},  // R6 still valid
        '{32'd4116,  OP_CHK, 16'h0000, 16'h0000, 5'd3,  1'b1, 4'd8},  // R8 lowest slot
        '{32'd4220,  OP_DRV, 16'h0000, 16'h0000, 5'd1,  1'b0, 4'd7},  // R7 clear
        '{32'd4221,  OP_CHK, 16'h0000, 16'h0000, 5'd0,  1'b0, 4'd7},  // R7
        '{32'd4320,  OP_DRV, 16'h0020, 16'h0000, 5'd0,  1'b0, 4'd9},  // R9 alloc 5
        '{32'd7000,  OP_DRV, 16'h0000, 16'h0020, 5'd0,  1'b0, 4'd9},  // R9 free 5 early
        '{32'd8213,  OP_CHK, 16'h0408, 16'hFFFF, 5'd0,  1'b0, 4'd9},  // R9 no repeat
        '{32'd8320,  OP_DRV, 16'h0400, 16'h0000, 5'd0,  1'b0, 4'd9},  // R9 realloc 10
        '{32'd10320, OP_DRV, 16'h0002, 16'h0000, 5'd0,  1'b0, 4'd8},  // R8 alloc 1
        '{32'd12307, OP_CHK, 16'h0000, 16'h0000, 5'd0,  1'b0, 4'd5},  // R5
        '{32'd12308, OP_CHK, 16'h040A, 16'hFFFF, 5'd10, 1'b1, 4'd9},  // R9 new error
        '{32'd14357, OP_CHK, 16'h040A, 16'hFFFF, 5'd10, 1'b1, 4'd8},  // R8 held
        '{32'd14420, OP_DRV, 16'h0006, 16'h0006, 5'd0,  1'b0, 4'd10}, // R10 both strobes
        '{32'd14421, OP_CHK, 16'h040E, 16'hFFFF, 5'd10, 1'b1, 4'd10}, // R10
        '{32'd14460, OP_DRV, 16'h0000, 16'h0000, 5'd1,  1'b0, 4'd7},  // R7 clear
        '{32'd14461, OP_CHK, 16'h0000, 16'h0000, 5'd0,  1'b0, 4'd7},  // R7
        '{32'd18451, OP_CHK, 16'h0000, 16'h0000, 5'd0,  1'b0, 4'd10}, // R10 age restarted
        '{32'd18452, OP_CHK, 16'h040E, 16'hFFFF, 5'd1,  1'b1, 4'd10}, // R10
        '{32'd18520, OP_DRV, 16'h0010, 16'h0000, 5'd0,  1'b0, 4'd7},  // R7 alloc 4
        '{32'd22548, OP_DRV, 16'h0000, 16'h0000, 5'd1,  1'b0, 4'd7},  // R7 clear on expiry edge
        '{32'd22548, OP_CHK, 16'h041E, 16'hFFFF, 5'd4,  1'b1, 4'd7},  // R7 set wins
        '{32'd22600, OP_CFG, 16'h0000, 16'h0000, 5'd2,  1'b0, 4'd4},  // R4 clamps to 8
        '{32'd22610, OP_DRV, 16'h0100, 16'h0000, 5'd1,  1'b0, 4'd4},  // R4 alloc 8 + clear
        '{32'd26695, OP_CHK, 16'h0000, 16'h0000, 5'd0,  1'b0, 4'd4},  // R4
        '{32'd26696, OP_CHK, 16'h0000, 16'h0000, 5'd8,  1'b1, 4'd4},  // R4
        '{32'd26800, OP_CFG, 16'h0000, 16'h0000, 5'd9,  1'b0, 4'd3},  // R3 width 9
        '{32'd26810, OP_DRV, 16'h0040, 16'h0000, 5'd1,  1'b0, 4'd3},  // R3 alloc 6 + clear
        '{32'd30896, OP_CHK, 16'h0000, 16'h0000, 5'd0,  1'b0, 4'd3},  // R3
        '{32'd34991, OP_CHK, 16'h0000, 16'h0000, 5'd0,  1'b0, 4'd3},  // R3
        '{32'd34992, OP_CHK, 16'h0000, 16'h0000, 5'd6,  1'b1, 4'd3}   // R3 period 4096
    };

    task automatic goto_edge(input int n);
        while (edges != n) @(negedge clk);
    endtask

    task automatic check_out(input int req, input logic ef, input logic [3:0] eidx,
                             input logic [15:0] ev, input logic [15:0] care);
        logic ok;
        ok = (fatal_o == ef) && (irq_o == ef) && (!ef || first_idx_o == eidx)
             && ((entry_valid_o & care) == (ev & care));
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL R%0d edge %0d: fatal=%0b irq=%0b idx=%0d valid=%h expected fatal=%0b idx=%0d valid=%h mask=%h",
                     req, edges, fatal_o, irq_o, first_idx_o, entry_valid_o, ef, eidx, ev, care);
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired at edge %0d", edges);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        goto_edge(5);
        rst_n = 1'b1;
        for (int k = 0; k < NR; k++) begin
            row_t r;
            r = ROWS[k];
            if (r.op == OP_DRV) begin
                goto_edge(int'(r.t) - 1);
                alloc_i     = r.a;
                dealloc_i   = r.d;
                cfg_we_i    = r.aux[0];
                cfg_addr_i  = 1'b1;
                cfg_wdata_i = 5'd1;
                goto_edge(int'(r.t));
                alloc_i   = '0;
                dealloc_i = '0;
                cfg_we_i  = 1'b0;
            end else if (r.op == OP_CFG) begin
                goto_edge(int'(r.t) - 1);
                cfg_we_i    = 1'b1;
                cfg_addr_i  = 1'b0;
                cfg_wdata_i = r.aux;
                goto_edge(int'(r.t));
                cfg_we_i = 1'b0;
            end else begin
                goto_edge(int'(r.t));
                check_out(int'(r.req), r.ef, r.aux[3:0], r.a, r.d);
            end
        end

        // R1: reset in mid-run clears the latched error and all slots
        rst_n = 1'b0;
        goto_edge(edges + 2);
        check_out(1, 1'b0, 4'd0, 16'h0000, 16'hFFFF);
        if (first_idx_o != 4'd0) begin
            bad++;
            $display("FAIL R1 idx after reset: actual=%0d expected=0", first_idx_o);
        end
        total++;
        rst_n = 1'b1;

        // R2: deallocating a free slot does nothing, allocate of slot 0 works
        goto_edge(edges + 1);
        alloc_i   = 16'h0001;
        dealloc_i = 16'h0080;
        goto_edge(edges + 1);
        alloc_i   = '0;
        dealloc_i = '0;
        check_out(2, 1'b0, 4'd0, 16'h0001, 16'hFFFF);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule